// File: doc/BRIEF.md
# SDR SDRAM Command Controller

This block sits between a simple word-request port and one 16-bit single-data-rate SDRAM with four banks. Each accepted request becomes a closed-page access. The block opens the row with an activate command, then issues one read or write that carries the auto-precharge flag, so the bank closes again by itself. The block also issues periodic auto refresh. After reset it runs a fixed power-up program before it takes any request. It drives the command, bank, address and byte-mask pins from registers, and drives the data bus through separate out, enable and in paths. It captures returned read data a CAS latency after the read command and presents it on a one-cycle strobe.

Requests use a valid/ready handshake. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. While `req_ready` is low the host must hold `req_valid` and all request fields steady. `req_ready` is high only when the controller is idle, initialisation is complete and no refresh is due. Read data has no back-pressure: `rd_valid` pulses for one cycle, and read results return in the order the requests were accepted.

Host word addresses are split as {row[11:0], bank[1:0], column[7:0]}. All timing constraints are module parameters counted in clock cycles.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: The command is driven on {cs_n, ras_n, cas_n, we_n} with the codes NOP=0111, READ=0101, WRITE=0100, ACTIVE=0011, PRECHARGE=0010, REFRESH=0001 and MODE SET=0000. No other code is ever driven. During reset, and whenever nothing is being issued, the code is NOP.
- R2: After reset the block drives at least T_INIT NOP cycles. It then issues, in this order: PRECHARGE with A10=1 (all banks); REFRESH; REFRESH; MODE SET with BA=00 and A = CAS_LAT<<4 (A[2:0]=000 selects burst length 1, A[6:4] holds the CAS latency); MODE SET with BA=10 and A=EMR_VAL (extended register).
- R3: For an accepted request, ACTIVE carries BA=bank and A=row. The following READ or WRITE carries the same BA and the column on A[7:0].
- R4: Every READ and WRITE drives A10=1 (auto precharge). A11 and A9..A8 are 0 on these commands.
- R5: READ/WRITE comes exactly T_RCD cycles after its ACTIVE. An ACTIVE to a bank comes at least T_RC after the previous ACTIVE to that bank, and at least T_RP after that bank's precharge starts. The precharge starts at the READ, or T_WR cycles after the WRITE. Consecutive initialisation commands and any command after a REFRESH keep the gaps T_RP, T_RFC and T_MRD. After a READ/WRITE the controller waits POST = max(T_RC−T_RCD, T_WR+T_RP+1, CAS_LAT+2, 2) cycles before its next command.
- R6: On a WRITE cycle, sd_dq_oe=1, sd_dq_out equals the write data, and sd_dqm equals the inverted byte enables (bit 0 covers DQ[7:0], bit 1 covers DQ[15:8]). A masked byte leaves memory unchanged. sd_dq_oe is 0 on every other cycle.
- R7: sd_dqm is 0 from a READ command until its data returns. The data present on sd_dq_in CAS_LAT cycles after the READ is sampled appears on rd_data, with rd_valid high for one cycle, exactly one cycle later.
- R8: A refresh falls due every T_REFI cycles once initialisation is done. Consecutive REFRESH commands are T_REFI±(T_RCD+POST+3) cycles apart. A REFRESH is issued only when every bank satisfies T_RP and T_RC.
- R9: Each accepted request produces exactly one ACTIVE followed by one READ/WRITE of the matching type, in acceptance order. req_ready is low in the cycle after an acceptance and for as long as an access is in progress. A due refresh is served before the next waiting request.
- R10: req_ready stays low until T_MRD cycles after the extended mode set, counting from the cycle in which the resulting ACTIVE could appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the SDRAM samples on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_addr | input | 22 | Word address {row, bank, column} |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 16 | Captured read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 12 | Address / op-code |
| sd_dqm | output | 2 | Byte masks, bit 0 = DQ[7:0] |
| sd_dq_out | output | 16 | Data driven to the memory |
| sd_dq_oe | output | 1 | Output enable for sd_dq_out |
| sd_dq_in | input | 16 | Data returned from the memory |

## Verification
The hardest case to reach is a refresh that falls due while the host is holding a request against a busy controller. Priority, back-pressure and bank-idle timing all meet at that point. The bench uses a short refresh interval and a long pseudo-random stream of back-to-back reads and writes with partial byte enables over a small address set, so refresh deadlines land at every phase of an access. A behavioural memory model on the pins checks every command's timing on each clock. Masked writes show up only in the data of later reads, which is checked against a host-level shadow memory.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } sdc_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT, ST_PALL, ST_REF1, ST_REF2, ST_MRS, ST_EMRS, ST_IDLE, ST_RW
  } sdc_state_e;

  localparam int AP_BIT = 10;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
  parameter int T_REFI = 390
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack,
  output logic due
);
  localparam int CW = $clog2(T_REFI + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CW'(T_REFI - 1);
      due <= 1'b0;
    end else if (!en) begin
      cnt <= CW'(T_REFI - 1);
      due <= 1'b0;
    end else begin
      if (cnt == '0) cnt <= CW'(T_REFI - 1);
      else           cnt <= cnt - 1'b1;
      due <= (due & ~ack) | (cnt == '0);
    end
  end

  // R8: a due refresh stays requested until the sequencer takes it
  a_r8_due_held: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !ack && en) |=> due);

endmodule

// File: rtl/sdc_read_capture.sv
module sdc_read_capture #(
  parameter int CAS_LAT = 2,
  parameter int DQ_W    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_issued,
  input  logic [DQ_W-1:0] dq_in,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_data
);
  logic [CAS_LAT-1:0] sr;

  generate
    if (CAS_LAT == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= rd_issued;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[CAS_LAT-2:0], rd_issued};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= sr[CAS_LAT-1];
      if (sr[CAS_LAT-1]) rd_data <= dq_in;
    end
  end

  // R7: a strobe only follows a read on the pins CAS_LAT+1 cycles earlier
  a_r7_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_issued, CAS_LAT + 1));

endmodule

// File: rtl/sdc_sequencer.sv
module sdc_sequencer
  import sdc_pkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int BANK_W  = 2,
  parameter int COL_W   = 8,
  parameter int DQ_W    = 16,
  parameter int T_INIT  = 100,
  parameter int T_RP    = 2,
  parameter int T_RCD   = 2,
  parameter int T_RC    = 6,
  parameter int T_WR    = 2,
  parameter int T_RFC   = 7,
  parameter int T_MRD   = 2,
  parameter int CAS_LAT = 2,
  parameter int EMR_VAL = 32,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W,
  localparam int BE_W   = DQ_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DQ_W-1:0]   req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic              ref_due,
  output logic              ref_ack,
  output logic              init_done,
  output sdc_cmd_e          cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  a_o,
  output logic [BE_W-1:0]   dqm_o,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o
);
  localparam int G_RP   = max2(T_RP, 2);
  localparam int G_RCD  = max2(T_RCD, 2);
  localparam int G_RFC  = max2(T_RFC, 2);
  localparam int G_MRD  = max2(T_MRD, 2);
  localparam int G_POST = max2(max2(T_RC - T_RCD, T_WR + T_RP + 1),
                               max2(CAS_LAT + 2, 2));
  localparam int CNT_TOP = max2(max2(T_INIT, G_RFC), max2(G_POST, G_RCD));
  localparam int CW      = $clog2(CNT_TOP + 1);

  sdc_state_e          state, nxt_q;
  logic [CW-1:0]       wcnt;
  logic [BANK_W-1:0]   lat_bank;
  logic [ROW_W-1:0]    lat_row;
  logic [COL_W-1:0]    lat_col;
  logic                lat_we;
  logic [DQ_W-1:0]     lat_data;
  logic [BE_W-1:0]     lat_be;

  assign req_ready = (state == ST_IDLE) && !ref_due;
  assign ref_ack   = (state == ST_IDLE) && ref_due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_WAIT;
      nxt_q     <= ST_PALL;
      wcnt      <= CW'(T_INIT - 1);
      init_done <= 1'b0;
      cmd_o     <= CMD_NOP;
      ba_o      <= '0;
      a_o       <= '0;
      dqm_o     <= '0;
      dq_o      <= '0;
      dq_oe_o   <= 1'b0;
      lat_bank  <= '0;
      lat_row   <= '0;
      lat_col   <= '0;
      lat_we    <= 1'b0;
      lat_data  <= '0;
      lat_be    <= '0;
    end else begin
      cmd_o   <= CMD_NOP;
      ba_o    <= '0;
      a_o     <= '0;
      dqm_o   <= '0;
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
      case (state)
        ST_WAIT: begin
          if (wcnt == '0) state <= nxt_q;
          else            wcnt  <= wcnt - 1'b1;
        end
        ST_PALL: begin
          cmd_o       <= CMD_PRE;
          a_o[AP_BIT] <= 1'b1;
          wcnt  <= CW'(G_RP - 2);
          nxt_q <= ST_REF1;
          state <= ST_WAIT;
        end
        ST_REF1: begin
          cmd_o <= CMD_REF;
          wcnt  <= CW'(G_RFC - 2);
          nxt_q <= ST_REF2;
          state <= ST_WAIT;
        end
        ST_REF2: begin
          cmd_o <= CMD_REF;
          wcnt  <= CW'(G_RFC - 2);
          nxt_q <= ST_MRS;
          state <= ST_WAIT;
        end
        ST_MRS: begin
          cmd_o <= CMD_MRS;
          ba_o  <= '0;
          a_o   <= ROW_W'(CAS_LAT) << 4;
          wcnt  <= CW'(G_MRD - 2);
          nxt_q <= ST_EMRS;
          state <= ST_WAIT;
        end
        ST_EMRS: begin
          cmd_o     <= CMD_MRS;
          ba_o      <= BANK_W'(2);
          a_o       <= ROW_W'(EMR_VAL);
          init_done <= 1'b1;
          wcnt  <= CW'(G_MRD - 2);
          nxt_q <= ST_IDLE;
          state <= ST_WAIT;
        end
        ST_IDLE: begin
          if (ref_due) begin
            cmd_o <= CMD_REF;
            wcnt  <= CW'(G_RFC - 2);
            nxt_q <= ST_IDLE;
            state <= ST_WAIT;
          end else if (req_valid) begin
            lat_col  <= req_addr[COL_W-1:0];
            lat_bank <= req_addr[COL_W +: BANK_W];
            lat_row  <= req_addr[COL_W+BANK_W +: ROW_W];
            lat_we   <= req_write;
            lat_data <= req_wdata;
            lat_be   <= req_be;
            cmd_o    <= CMD_ACT;
            ba_o     <= req_addr[COL_W +: BANK_W];
            a_o      <= req_addr[COL_W+BANK_W +: ROW_W];
            wcnt  <= CW'(G_RCD - 2);
            nxt_q <= ST_RW;
            state <= ST_WAIT;
          end
        end
        ST_RW: begin
          cmd_o            <= lat_we ? CMD_WR : CMD_RD;
          ba_o             <= lat_bank;
          a_o[COL_W-1:0]   <= lat_col;
          a_o[AP_BIT]      <= 1'b1;
          if (lat_we) begin
            dq_oe_o <= 1'b1;
            dq_o    <= lat_data;
            dqm_o   <= ~lat_be;
          end
          wcnt  <= CW'(G_POST - 2);
          nxt_q <= ST_IDLE;
          state <= ST_WAIT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: column commands always request auto precharge
  a_r4_autopre: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_RD || cmd_o == CMD_WR) |-> a_o[AP_BIT]);
  // R6: the data bus is driven only alongside a write
  a_r6_oe_write: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_o |-> (cmd_o == CMD_WR));
  // R5: an activate is never immediately followed by another command
  a_r5_act_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_ACT) |=> (cmd_o == CMD_NOP));
  // R9: an accepted request opens its row on the next cycle
  a_r9_accept_act: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_o == CMD_ACT));
  // R10: no request is taken before the power-up program has finished
  a_r10_ready_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> init_done);

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdc_pkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int BANK_W  = 2,
  parameter int COL_W   = 8,
  parameter int DQ_W    = 16,
  parameter int T_INIT  = 100,
  parameter int T_RP    = 2,
  parameter int T_RCD   = 2,
  parameter int T_RC    = 6,
  parameter int T_WR    = 2,
  parameter int T_RFC   = 7,
  parameter int T_MRD   = 2,
  parameter int CAS_LAT = 2,
  parameter int T_REFI  = 390,
  parameter int EMR_VAL = 32,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W,
  localparam int BE_W   = DQ_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DQ_W-1:0]   req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [BE_W-1:0]   sd_dqm,
  output logic [DQ_W-1:0]   sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DQ_W-1:0]   sd_dq_in
);
  sdc_cmd_e cmd;
  logic     ref_due, ref_ack, init_done;

  sdc_sequencer #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .DQ_W(DQ_W),
    .T_INIT(T_INIT), .T_RP(T_RP), .T_RCD(T_RCD), .T_RC(T_RC), .T_WR(T_WR),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .CAS_LAT(CAS_LAT), .EMR_VAL(EMR_VAL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_be(req_be),
    .ref_due(ref_due), .ref_ack(ref_ack), .init_done(init_done),
    .cmd_o(cmd), .ba_o(sd_ba), .a_o(sd_a), .dqm_o(sd_dqm),
    .dq_o(sd_dq_out), .dq_oe_o(sd_dq_oe)
  );

  sdc_refresh_timer #(.T_REFI(T_REFI)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(init_done), .ack(ref_ack), .due(ref_due)
  );

  sdc_read_capture #(.CAS_LAT(CAS_LAT), .DQ_W(DQ_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .rd_issued(cmd == CMD_RD), .dq_in(sd_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

endmodule

// File: tb/test_sdram_cmd_ctrl.sv
module test_sdram_cmd_ctrl;
  localparam int T_INIT = 100, T_RP = 2, T_RCD = 2, T_RC = 6, T_WR = 2;
  localparam int T_RFC = 7, T_MRD = 2, CL = 2, T_REFI = 390, EMR = 32;
  localparam int POST = 5;                 // max(T_RC-T_RCD, T_WR+T_RP+1, CL+2, 2)
  localparam int DREF = T_RCD + POST + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] dq_in = 16'hBAD0;
  logic req_ready, rd_valid, cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [15:0] rd_data, dq_out;
  logic [1:0]  ba, dqm;
  logic [11:0] a;

  always #10 clk = ~clk;

  sdram_cmd_ctrl #(.T_INIT(T_INIT), .T_RP(T_RP), .T_RCD(T_RCD), .T_RC(T_RC),
    .T_WR(T_WR), .T_RFC(T_RFC), .T_MRD(T_MRD), .CAS_LAT(CL), .T_REFI(T_REFI),
    .EMR_VAL(EMR)) i_sdram_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_ba(ba), .sd_a(a), .sd_dqm(dqm), .sd_dq_out(dq_out), .sd_dq_oe(dq_oe),
    .sd_dq_in(dq_in));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // reference state
  int cyc = 0, rst_rel = -1, init_step = 0, last_cmd = 0, init_end = 0;
  int last_ref = -100000, prev_ref = -1;
  int act_cyc[4], pre_cyc[4];
  logic [11:0] row_open[4];
  logic [21:0] q_addr[$];
  bit          q_we[$];
  logic [15:0] q_data[$], q_exp[$];
  logic [1:0]  q_be[$];
  logic [15:0] rd_exp[$];
  int          rd_due[$], drv_cyc[$];
  logic [15:0] drv_dat[$];
  logic [15:0] pmem[int], smem[int];
  bit          have_cur = 0, cur_we, acc_prev = 0;
  logic [21:0] cur_addr;
  logic [15:0] cur_data, cur_exp;
  logic [1:0]  cur_be;
  int          cur_act;
  int          n_ref_post = 0, n_mask_wr = 0;

  function automatic logic [15:0] mrd(ref logic [15:0] m[int], input int k);
    return m.exists(k) ? m[k] : 16'h0000;
  endfunction

  initial for (int b = 0; b < 4; b++) begin
    act_cyc[b] = -100000; pre_cyc[b] = -100000; row_open[b] = '0;
  end

  always @(negedge clk) begin : monitor
    logic [3:0] cmd;
    int k;
    logic [15:0] v;
    cyc++;
    cmd = {cs_n, ras_n, cas_n, we_n};
    if (rst_n) begin
      if (rst_rel < 0) rst_rel = cyc;
      if (acc_prev) chk(!req_ready, "R9", "ready after accept", req_ready, 0);
      if (req_ready && (init_step < 5 || cyc < init_end + T_MRD - 1))
        chk(0, "R10", "ready before init end", cyc, init_end + T_MRD - 1);
      if (req_ready && have_cur) chk(0, "R9", "ready during access", 1, 0);
      if (dq_oe && cmd != 4'b0100) chk(0, "R6", "oe without write", cmd, 4'b0100);
      if (drv_cyc.size() > 0 && drv_cyc[0] - 2 == cyc)
        chk(dqm == 2'b00, "R7", "dqm before read data", dqm, 0);
      case (cmd)
        4'b0111: ;
        4'b0010: begin
          chk(init_step == 0, "R2", "precharge order", init_step, 0);
          chk(a[10] == 1'b1, "R2", "precharge-all A10", a[10], 1);
          chk(cyc - rst_rel >= T_INIT, "R2", "power-up NOPs", cyc - rst_rel, T_INIT);
          for (int b = 0; b < 4; b++) pre_cyc[b] = cyc;
          init_step = 1; last_cmd = cyc;
        end
        4'b0001: begin
          if (init_step == 1 || init_step == 2) begin
            chk(cyc - last_cmd >= (init_step == 1 ? T_RP : T_RFC), "R5",
                "init refresh gap", cyc - last_cmd, T_RP);
            init_step++;
          end else if (init_step == 5) begin
            for (int b = 0; b < 4; b++)
              chk(cyc >= pre_cyc[b] + T_RP && cyc >= act_cyc[b] + T_RC, "R8",
                  "refresh with bank busy", cyc, pre_cyc[b] + T_RP);
            chk(cyc >= last_ref + T_RFC, "R5", "refresh to refresh", cyc, last_ref + T_RFC);
            if (prev_ref >= 0)
              chk(cyc - prev_ref >= T_REFI - DREF && cyc - prev_ref <= T_REFI + DREF,
                  "R8", "refresh interval", cyc - prev_ref, T_REFI);
            prev_ref = cyc; n_ref_post++;
          end else chk(0, "R2", "unexpected refresh", init_step, 5);
          last_ref = cyc; last_cmd = cyc;
        end
        4'b0000: begin
          if (init_step == 3) begin
            chk(ba == 2'b00 && a == 12'(CL << 4), "R2", "mode word", {ba, a}, CL << 4);
            chk(cyc - last_cmd >= T_RFC, "R5", "mode set gap", cyc - last_cmd, T_RFC);
            init_step = 4;
          end else if (init_step == 4) begin
            chk(ba == 2'b10 && a == 12'(EMR), "R2", "ext mode word", {ba, a}, (2 << 12) | EMR);
            chk(cyc - last_cmd >= T_MRD, "R5", "ext mode gap", cyc - last_cmd, T_MRD);
            init_step = 5; init_end = cyc;
          end else chk(0, "R2", "unexpected mode set", init_step, 3);
          last_cmd = cyc;
        end
        4'b0011: begin
          chk(init_step == 5, "R10", "activate before init", init_step, 5);
          if (q_addr.size() == 0) chk(0, "R9", "activate without request", 0, 1);
          else begin
            cur_addr = q_addr.pop_front(); cur_we = q_we.pop_front();
            cur_data = q_data.pop_front(); cur_be = q_be.pop_front();
            cur_exp = q_exp.pop_front(); have_cur = 1; cur_act = cyc;
            chk(ba == cur_addr[9:8] && a == cur_addr[21:10], "R3", "activate bank/row",
                {ba, a}, {cur_addr[9:8], cur_addr[21:10]});
          end
          chk(cyc >= pre_cyc[ba] + T_RP, "R5", "tRP", cyc, pre_cyc[ba] + T_RP);
          chk(cyc >= act_cyc[ba] + T_RC, "R5", "tRC", cyc, act_cyc[ba] + T_RC);
          chk(cyc >= last_ref + T_RFC, "R5", "tRFC", cyc, last_ref + T_RFC);
          act_cyc[ba] = cyc; row_open[ba] = a;
        end
        4'b0100, 4'b0101: begin
          chk(have_cur, "R9", "column cmd without activate", 0, 1);
          chk(cyc - cur_act == T_RCD, "R5", "tRCD", cyc - cur_act, T_RCD);
          chk(ba == cur_addr[9:8] && a[7:0] == cur_addr[7:0], "R3", "column bank/col",
              {ba, a[7:0]}, {cur_addr[9:8], cur_addr[7:0]});
          chk(a[10] && !a[11] && a[9:8] == 2'b00, "R4", "auto precharge bits", a, 12'h400);
          chk((cmd == 4'b0100) == cur_we, "R9", "command type", cmd, cur_we ? 4 : 5);
          k = int'({ba, row_open[ba], a[7:0]});
          if (cmd == 4'b0100) begin
            chk(dq_oe && dq_out == cur_data, "R6", "write data", dq_out, cur_data);
            chk(dqm == ~cur_be, "R6", "write mask", dqm, ~cur_be);
            v = mrd(pmem, k);
            if (!dqm[0]) v[7:0] = dq_out[7:0];
            if (!dqm[1]) v[15:8] = dq_out[15:8];
            pmem[k] = v;
            pre_cyc[ba] = cyc + T_WR;
          end else begin
            chk(dqm == 2'b00 && !dq_oe, "R7", "read dqm/oe", {dq_oe, dqm}, 0);
            drv_cyc.push_back(cyc + CL); drv_dat.push_back(mrd(pmem, k));
            rd_exp.push_back(cur_exp); rd_due.push_back(cyc + CL + 1);
            pre_cyc[ba] = cyc;
          end
          have_cur = 0;
        end
        default: chk(0, "R1", "illegal command code", cmd, 4'b0111);
      endcase
      if (rd_valid) begin
        if (rd_exp.size() == 0) chk(0, "R7", "unexpected rd_valid", 1, 0);
        else begin
          chk(rd_due[0] == cyc, "R7", "read latency", cyc, rd_due[0]);
          chk(rd_data == rd_exp[0], "R7", "read data", rd_data, rd_exp[0]);
          void'(rd_exp.pop_front()); void'(rd_due.pop_front());
        end
      end else if (rd_due.size() > 0 && rd_due[0] <= cyc)
        chk(0, "R7", "missing rd_valid", 0, 1);
      if (drv_cyc.size() > 0 && drv_cyc[0] == cyc) begin
        dq_in = drv_dat.pop_front(); void'(drv_cyc.pop_front());
      end else dq_in = 16'hBAD0;
      acc_prev = req_valid && req_ready;
      if (acc_prev) begin
        k = int'({req_addr[9:8], req_addr[21:10], req_addr[7:0]});
        q_addr.push_back(req_addr); q_we.push_back(req_write);
        q_data.push_back(req_wdata); q_be.push_back(req_be);
        if (req_write) begin
          v = mrd(smem, k);
          if (req_be[0]) v[7:0] = req_wdata[7:0];
          if (req_be[1]) v[15:8] = req_wdata[15:8];
          smem[k] = v;
          if (req_be != 2'b11) n_mask_wr++;
        end
        q_exp.push_back(mrd(smem, k));
      end
    end
  end

  task automatic do_req(input bit we, input logic [21:0] ad,
                        input logic [15:0] d, input logic [1:0] be);
    bit ok;
    @(posedge clk); #5;
    req_valid = 1'b1; req_write = we; req_addr = ad; req_wdata = d; req_be = be;
    do begin
      @(negedge clk); ok = req_ready;
      @(posedge clk); #5;
    end while (!ok);
    req_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin : stim
    logic [15:0] lf;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "reset command", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(!req_ready && !rd_valid && !dq_oe, "R1", "reset outputs", {req_ready, rd_valid, dq_oe}, 0);
    @(posedge clk); #5; rst_n = 1'b1;
    wait (init_step == 5);
    // R6 R7: full, partial and empty byte enables, seen through reads
    do_req(1, 22'h000012, 16'h1234, 2'b11);
    do_req(0, 22'h000012, 16'h0000, 2'b00);
    do_req(1, 22'h000012, 16'hABCD, 2'b01);
    do_req(0, 22'h000012, 16'h0000, 2'b00);
    do_req(1, 22'h000012, 16'h5566, 2'b10);
    do_req(1, 22'h000012, 16'hFFFF, 2'b00);
    do_req(0, 22'h000012, 16'h0000, 2'b11);
    // R3: every bank, extreme rows and columns
    for (int b = 0; b < 4; b++)
      do_req(1, {12'hFFF - 12'(b), 2'(b), 8'hFF - 8'(b)}, 16'hC000 + 16'(b), 2'b11);
    for (int b = 0; b < 4; b++)
      do_req(0, {12'hFFF - 12'(b), 2'(b), 8'hFF - 8'(b)}, 16'h0, 2'b11);
    do_req(1, 22'h3FFFFF, 16'h7E7E, 2'b11);
    do_req(0, 22'h3FFFFF, 16'h0, 2'b11);
    do_req(0, 22'h000000, 16'h0, 2'b11);
    // R8: idle across several refresh periods
    repeat (3 * T_REFI) @(posedge clk);
    // R8 R9: dense pseudo-random stream colliding with refresh
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_req(lf[0], {9'b0, lf[6:4], lf[8:7], 5'b0, lf[11:9]}, lf ^ 16'h5A5A, lf[13:12]);
      if (lf[15:14] == 2'b00) repeat (int'(lf[3:1])) @(posedge clk);
    end
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(q_addr.size() == 0 && !have_cur, "R9", "requests left unserved", q_addr.size(), 0);
    chk(rd_exp.size() == 0, "R7", "reads left unanswered", rd_exp.size(), 0);
    chk(n_ref_post >= 8, "R8", "refresh count", n_ref_post, 8);
    chk(n_mask_wr > 0, "R6", "masked writes exercised", n_mask_wr, 1);
    finish_run();
  end

endmodule